// File: doc/BRIEF.md
# Element-Width-Aware Integer Shift Unit

This block is the shift stage of a vector-style integer datapath in which every element operand carries its own width tag. The two source operands and the destination may each be 8, 16, 32 or 64 bits wide. The unit takes the larger of the two source widths as its working width. The destination width plays no part in that choice. Both operands are conditioned to the working width, and the unit then performs a logical left shift, a logical right shift or an arithmetic right shift. The outcome is widened by sign extension or narrowed by truncation to fit the destination element.

The datapath is combinational. One output register stage sits at the end of it, qualified by an input valid and an output valid. The caller presents a complete element operation on one cycle. The fitted destination element appears on the result bus on the following cycle.

Top module: `ews_shift_unit`

## Requirements
- R1: The working width W equals the larger of the two source element widths; the destination width tag never changes W.
- R2: Each width tag is 2 bits: 00 = 8 bits, 01 = 16 bits, 10 = 32 bits, 11 = 64 bits.
- R3: The shift amount is the low 6 bits of the second source ANDed with (W - 1), so it always lies in 0 .. W-1.
- R4: For a left shift, the first source is zero-extended from its own element width, shifted, and only the low W bits of the shifted value are kept.
- R5: For a logical right shift, the first source is zero-extended from its own element width and zeros enter from the top of the W-bit field.
- R6: For an arithmetic right shift, the first source is sign-extended from its own element width up to W, and copies of bit W-1 enter from the top.
- R7: When the destination is wider than W, the W-bit result is sign-extended from bit W-1 to the destination width.
- R8: When the destination is narrower than W, the result is truncated to the destination width. Bits of the result bus above the destination width are always zero.
- R9: The operation code is 2 bits: 00 = left shift, 01 = logical right shift, 10 = arithmetic right shift, 11 = reserved, which yields an all-zero element.
- R10: An operation accepted with in_valid high appears on the result bus with out_valid high one clock later. A cycle with in_valid low gives out_valid low on the next cycle and leaves the result bus unchanged.
- R11: While rst_n is low at a clock edge, out_valid and the result bus clear to zero on that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation present on the inputs this cycle |
| shift_op | input | 2 | Operation code (R9) |
| src1_ew | input | 2 | Width tag of the value to be shifted |
| src2_ew | input | 2 | Width tag of the shift-amount operand |
| dst_ew | input | 2 | Width tag of the destination element |
| src1_data | input | 64 | Value to be shifted, element in the low bits |
| src2_data | input | 64 | Shift-amount operand, element in the low bits |
| out_valid | output | 1 | Result bus holds a fresh element |
| out_data | output | 64 | Destination element, zero above its width |

## Verification
Every result of this unit is due exactly one rising edge after the edge that samples in_valid. The bench drives its inputs on the falling edge and reads the outputs on the next falling edge, so each sample falls half a period after the single register has updated. A behavioural model is advanced on the same rising edges and compared against out_valid and out_data on every falling edge. Directed operations with hand-computed results are read in that same cycle, and idle cycles are checked in their following cycle for a cleared out_valid and an unchanged result.

// File: rtl/ews_pkg.sv
// Package ews_pkg
// Shared encodings for the element-width-aware shift unit.
// Assumes: width tags and operation codes are both 2 bits wide.
package ews_pkg;

    // Element width tag; the numeric order matches the width order.
    typedef enum logic [1:0] {
        EW_8  = 2'b00,
        EW_16 = 2'b01,
        EW_32 = 2'b10,
        EW_64 = 2'b11
    } ew_tag_e;

    // Shift operation code.
    typedef enum logic [1:0] {
        OP_SLL = 2'b00,
        OP_SRL = 2'b01,
        OP_SRA = 2'b10,
        OP_RSV = 2'b11
    } shift_op_e;

endpackage

// File: rtl/ews_width_sel.sv
// Module ews_width_sel
// Chooses the working width from the two source tags and turns the tags
// into low-bit masks of the data bus.
// Assumes: tag codes grow with width, so an unsigned compare orders them.
module ews_width_sel #(
    parameter int TAG_W  = 2,
    parameter int BASE_W = 8,
    localparam int NUM_EW = 1 << TAG_W,
    localparam int DATA_W = BASE_W << (NUM_EW - 1)
) (
    input  logic [TAG_W-1:0]  src1_ew,
    input  logic [TAG_W-1:0]  src2_ew,
    input  logic [TAG_W-1:0]  dst_ew,
    output logic [TAG_W-1:0]  op_ew,
    output logic [DATA_W-1:0] op_mask,
    output logic [DATA_W-1:0] s1_mask,
    output logic [DATA_W-1:0] dst_mask
);

    logic [DATA_W-1:0] mask_tbl [NUM_EW];

    // One constant mask per possible element width.
    for (genvar g = 0; g < NUM_EW; g++) begin : g_mask
        if (g == NUM_EW - 1) begin : g_full
            assign mask_tbl[g] = '1;
        end else begin : g_part
            assign mask_tbl[g] = {{(DATA_W - (BASE_W << g)){1'b0}},
                                  {(BASE_W << g){1'b1}}};
        end
    end

    // Working width: the larger of the two source tags.
    always_comb begin
        op_ew = (src1_ew > src2_ew) ? src1_ew : src2_ew;
    end

    // Look up the masks for the working, first-source and destination widths.
    always_comb begin
        op_mask  = mask_tbl[op_ew];
        s1_mask  = mask_tbl[src1_ew];
        dst_mask = mask_tbl[dst_ew];
    end

endmodule

// File: rtl/ews_operand_cond.sv
// Module ews_operand_cond
// Conditions the shifted value and the shift amount to the working width.
// Assumes: masks come from ews_width_sel; bits of the value above the
// working width leave this module as zero.
module ews_operand_cond
    import ews_pkg::*;
#(
    parameter int TAG_W  = 2,
    parameter int BASE_W = 8,
    localparam int NUM_EW = 1 << TAG_W,
    localparam int DATA_W = BASE_W << (NUM_EW - 1),
    localparam int SH_W   = $clog2(DATA_W)
) (
    input  logic [1:0]        shift_op,
    input  logic [TAG_W-1:0]  op_ew,
    input  logic [DATA_W-1:0] src1_data,
    input  logic [DATA_W-1:0] src2_data,
    input  logic [DATA_W-1:0] op_mask,
    input  logic [DATA_W-1:0] s1_mask,
    output logic [DATA_W-1:0] opa,
    output logic [SH_W-1:0]   shamt
);

    logic [DATA_W-1:0] s1_msb_1h;
    logic              s1_neg;
    logic [SH_W-1:0]   amt_mask;

    // Top bit of the first source element as a one-hot pattern.
    always_comb begin
        s1_msb_1h = s1_mask ^ (s1_mask >> 1);
        s1_neg    = |(src1_data & s1_msb_1h);
    end

    // Zero- or sign-extend the first source from its own width to W.
    always_comb begin
        if (shift_op == OP_SRA && s1_neg) begin
            opa = (src1_data | ~s1_mask) & op_mask;
        end else begin
            opa = src1_data & s1_mask & op_mask;
        end
    end

    // Shift amount reduced to 0 .. W-1.
    always_comb begin
        amt_mask = SH_W'((BASE_W << op_ew) - 1);
        shamt    = src2_data[SH_W-1:0] & amt_mask;
    end

endmodule

// File: rtl/ews_shift_core.sv
// Module ews_shift_core
// Performs the shift inside the W-bit field with a single logarithmic
// right shifter. A left shift reverses the bits before and after it.
// Assumes: opa is zero above W; the output is zero above W.
module ews_shift_core
    import ews_pkg::*;
#(
    parameter int TAG_W  = 2,
    parameter int BASE_W = 8,
    localparam int NUM_EW = 1 << TAG_W,
    localparam int DATA_W = BASE_W << (NUM_EW - 1),
    localparam int SH_W   = $clog2(DATA_W)
) (
    input  logic [1:0]        shift_op,
    input  logic [DATA_W-1:0] opa,
    input  logic [SH_W-1:0]   shamt,
    input  logic [DATA_W-1:0] op_mask,
    output logic [DATA_W-1:0] shifted
);

    logic [DATA_W-1:0]         opa_rev;
    logic [DATA_W-1:0]         pre;
    logic                      fill;
    logic [SH_W:0][DATA_W-1:0] stage;
    logic [DATA_W-1:0]         post_rev;
    logic                      op_neg;

    // Bit-reversed copy of the operand for the left-shift path.
    for (genvar b = 0; b < DATA_W; b++) begin : g_rev_in
        assign opa_rev[b] = opa[DATA_W-1-b];
    end

    // Choose the shifter input and the bit that enters from the top.
    always_comb begin
        op_neg = |(opa & (op_mask ^ (op_mask >> 1)));
        fill   = (shift_op == OP_SRA) && op_neg;
        case (shift_op)
            OP_SLL:  pre = opa_rev;
            OP_SRA:  pre = op_neg ? (opa | ~op_mask) : opa;
            default: pre = opa;
        endcase
    end

    assign stage[0] = pre;

    // One stage per shift-amount bit, each moving by a power of two.
    for (genvar k = 0; k < SH_W; k++) begin : g_stage
        assign stage[k+1] = shamt[k]
            ? {{(1 << k){fill}}, stage[k][DATA_W-1:(1 << k)]}
            : stage[k];
    end

    // Undo the reversal for the left-shift path.
    for (genvar b = 0; b < DATA_W; b++) begin : g_rev_out
        assign post_rev[b] = stage[SH_W][DATA_W-1-b];
    end

    // Select the finished field and clear everything above W.
    always_comb begin
        case (shift_op)
            OP_SLL:  shifted = post_rev & op_mask;
            OP_SRL,
            OP_SRA:  shifted = stage[SH_W] & op_mask;
            default: shifted = '0;
        endcase
    end

endmodule

// File: rtl/ews_result_fit.sv
// Module ews_result_fit
// Fits the W-bit shift result to the destination element: sign-extends
// from bit W-1 when the destination is wider, truncates when narrower.
// Assumes: shifted is zero above W.
module ews_result_fit #(
    parameter int TAG_W  = 2,
    parameter int BASE_W = 8,
    localparam int NUM_EW = 1 << TAG_W,
    localparam int DATA_W = BASE_W << (NUM_EW - 1)
) (
    input  logic [DATA_W-1:0] shifted,
    input  logic [DATA_W-1:0] op_mask,
    input  logic [DATA_W-1:0] dst_mask,
    output logic [DATA_W-1:0] fitted
);

    logic res_neg;

    // Extend from bit W-1, then keep only the destination field.
    always_comb begin
        res_neg = |(shifted & (op_mask ^ (op_mask >> 1)));
        fitted  = (res_neg ? (shifted | ~op_mask) : shifted) & dst_mask;
    end

endmodule

// File: rtl/ews_shift_unit.sv
// Module ews_shift_unit (top)
// Element-width-aware shift unit: width choice, operand conditioning,
// shift and destination fitting, followed by one output register.
// Assumes: a full operation is presented on a single in_valid cycle.
module ews_shift_unit #(
    parameter int TAG_W  = 2,
    parameter int BASE_W = 8,
    localparam int NUM_EW = 1 << TAG_W,
    localparam int DATA_W = BASE_W << (NUM_EW - 1),
    localparam int SH_W   = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        shift_op,
    input  logic [TAG_W-1:0]  src1_ew,
    input  logic [TAG_W-1:0]  src2_ew,
    input  logic [TAG_W-1:0]  dst_ew,
    input  logic [DATA_W-1:0] src1_data,
    input  logic [DATA_W-1:0] src2_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);

    logic [TAG_W-1:0]  op_ew;
    logic [DATA_W-1:0] op_mask;
    logic [DATA_W-1:0] s1_mask;
    logic [DATA_W-1:0] dst_mask;
    logic [DATA_W-1:0] opa;
    logic [SH_W-1:0]   shamt;
    logic [DATA_W-1:0] shifted;
    logic [DATA_W-1:0] fitted;

    ews_width_sel #(.TAG_W(TAG_W), .BASE_W(BASE_W)) u_width (
        .src1_ew  (src1_ew),
        .src2_ew  (src2_ew),
        .dst_ew   (dst_ew),
        .op_ew    (op_ew),
        .op_mask  (op_mask),
        .s1_mask  (s1_mask),
        .dst_mask (dst_mask)
    );

    ews_operand_cond #(.TAG_W(TAG_W), .BASE_W(BASE_W)) u_cond (
        .shift_op  (shift_op),
        .op_ew     (op_ew),
        .src1_data (src1_data),
        .src2_data (src2_data),
        .op_mask   (op_mask),
        .s1_mask   (s1_mask),
        .opa       (opa),
        .shamt     (shamt)
    );

    ews_shift_core #(.TAG_W(TAG_W), .BASE_W(BASE_W)) u_core (
        .shift_op (shift_op),
        .opa      (opa),
        .shamt    (shamt),
        .op_mask  (op_mask),
        .shifted  (shifted)
    );

    ews_result_fit #(.TAG_W(TAG_W), .BASE_W(BASE_W)) u_fit (
        .shifted  (shifted),
        .op_mask  (op_mask),
        .dst_mask (dst_mask),
        .fitted   (fitted)
    );

    // Output register: capture on in_valid, otherwise hold the last element.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_data <= fitted;
            end
        end
    end

endmodule

// File: rtl/ews_shift_unit_chk.sv
// Module ews_shift_unit_chk
// Port-level properties of the shift unit, bound to every instance.
// Assumes: the same parameters as the unit it is bound to.
module ews_shift_unit_chk #(
    parameter int TAG_W  = 2,
    parameter int BASE_W = 8,
    localparam int NUM_EW = 1 << TAG_W,
    localparam int DATA_W = BASE_W << (NUM_EW - 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [1:0]        shift_op,
    input logic [TAG_W-1:0]  src1_ew,
    input logic [TAG_W-1:0]  src2_ew,
    input logic [TAG_W-1:0]  dst_ew,
    input logic [DATA_W-1:0] src1_data,
    input logic [DATA_W-1:0] src2_data,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data
);

    function automatic logic [DATA_W-1:0] tag_mask(input logic [TAG_W-1:0] t);
        logic [DATA_W-1:0] m;
        m = '0;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < (BASE_W << t)) m[i] = 1'b1;
        end
        return m;
    endfunction

    // R11: reset clears the output stage on the next edge.
    a_r11_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_data == '0));

    // R10: an accepted operation is flagged one cycle later.
    a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R10: an idle cycle leaves out_valid low and the result unchanged.
    a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_data)));

    // R8: nothing above the destination width reaches the result bus.
    a_r8_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ((out_data & ~tag_mask($past(dst_ew))) == '0));

    // R9: the reserved operation code yields an all-zero element.
    a_r9_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && shift_op == 2'b11) |=> (out_data == '0));

    // R3: a zero shift amount passes a same-width element through unchanged.
    a_r3_zero_amount: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && shift_op != 2'b11 && src1_ew == src2_ew && dst_ew == src1_ew
         && (src2_data[5:0] & 6'((BASE_W << src1_ew) - 1)) == 6'd0)
        |=> (out_data == $past(src1_data & tag_mask(src1_ew))));

endmodule

bind ews_shift_unit ews_shift_unit_chk #(.TAG_W(TAG_W), .BASE_W(BASE_W)) u_chk (.*);

// File: tb/ews_shift_unit_tb.sv
module ews_shift_unit_tb;

    localparam int DW = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [1:0]    shift_op = 2'b00;
    logic [1:0]    src1_ew = 2'b00;
    logic [1:0]    src2_ew = 2'b00;
    logic [1:0]    dst_ew = 2'b00;
    logic [DW-1:0] src1_data = '0;
    logic [DW-1:0] src2_data = '0;
    logic          out_valid;
    logic [DW-1:0] out_data;

    int    n_checks = 0;
    int    n_fails  = 0;
    bit    done     = 0;
    bit    model_on = 0;
    string cur_req  = "R10";

    logic          m_valid = 1'b0;
    logic [DW-1:0] m_data  = '0;

    always #2 clk = ~clk;

    ews_shift_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .shift_op(shift_op),
        .src1_ew(src1_ew), .src2_ew(src2_ew), .dst_ew(dst_ew),
        .src1_data(src1_data), .src2_data(src2_data),
        .out_valid(out_valid), .out_data(out_data)
    );

    function automatic logic [DW-1:0] wmask(input int w);
        return (w >= DW) ? '1 : ((64'd1 << w) - 64'd1);
    endfunction

    // Behavioural reference computed straight from the requirements.
    function automatic logic [DW-1:0] ref_op(input logic [1:0] op, input logic [1:0] t1,
            input logic [1:0] t2, input logic [1:0] td,
            input logic [DW-1:0] a, input logic [DW-1:0] b);
        int w1 = 8 << t1;
        int w2 = 8 << t2;
        int w  = (w1 > w2) ? w1 : w2;
        int sh;
        logic [DW-1:0] x, r;
        x = a & wmask(w1);
        if (op == 2'd2 && x[w1-1]) x = x | ~wmask(w1);
        x = x & wmask(w);
        sh = int'(b[5:0]) % w;
        case (op)
            2'd0: r = (x << sh) & wmask(w);
            2'd1: r = x >> sh;
            2'd2: begin
                r = x[w-1] ? (x | ~wmask(w)) : x;
                r = DW'($signed(r) >>> sh) & wmask(w);
            end
            default: r = '0;
        endcase
        if (r[w-1]) r = r | ~wmask(w);
        return r & wmask(8 << td);
    endfunction

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Model advances on the same edges as the unit.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_valid <= 1'b0;
            m_data  <= '0;
        end else begin
            m_valid <= in_valid;
            if (in_valid)
                m_data <= ref_op(shift_op, src1_ew, src2_ew, dst_ew, src1_data, src2_data);
        end
    end

    // Per-cycle comparison half a period after each rising edge.
    always @(negedge clk) begin
        if (model_on) begin
            check({cur_req, " R10 valid"}, {63'd0, out_valid}, {63'd0, m_valid});
            check({cur_req, " model"}, out_data, m_data);
        end
    end

    // Drive one operation, then read its fixed expected result a cycle later.
    task automatic op_chk(input string req, input logic [1:0] op, input logic [1:0] t1,
            input logic [1:0] t2, input logic [1:0] td, input logic [DW-1:0] a,
            input logic [DW-1:0] b, input logic [DW-1:0] exp);
        cur_req   = req;
        in_valid  = 1'b1;
        shift_op  = op;
        src1_ew   = t1;
        src2_ew   = t2;
        dst_ew    = td;
        src1_data = a;
        src2_data = b;
        @(negedge clk);
        in_valid = 1'b0;
        #1;
        check({req, " directed"}, out_data, exp);
        check({req, " R10 valid"}, {63'd0, out_valid}, 64'd1);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] held;
        repeat (3) @(negedge clk);
        check("R11 valid after reset", {63'd0, out_valid}, 64'd0);
        check("R11 data after reset", out_data, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        model_on = 1;

        // Directed cases with hand-derived results.
        op_chk("R1 R3 source-width amount mask", 2'd0, 2'd0, 2'd1, 2'd1, 64'h81, 64'd17, 64'h0102);
        op_chk("R1 wide dst ignored", 2'd1, 2'd0, 2'd0, 2'd3, 64'hF0, 64'h0C, 64'h0F);
        op_chk("R7 sign extend to dst", 2'd0, 2'd0, 2'd0, 2'd2, 64'h41, 64'd1, 64'hFFFF_FF82);
        op_chk("R8 truncate to dst", 2'd1, 2'd2, 2'd0, 2'd0, 64'h1234_5678, 64'd4, 64'h67);
        op_chk("R6 arithmetic right", 2'd2, 2'd0, 2'd1, 2'd1, 64'h80, 64'd2, 64'hFFE0);
        op_chk("R5 logical right", 2'd1, 2'd0, 2'd1, 2'd1, 64'h80, 64'd2, 64'h0020);
        op_chk("R4 src1 zero-extend", 2'd0, 2'd0, 2'd1, 2'd1, 64'hFFFF_FF80, 64'd4, 64'h0800);
        op_chk("R4 keep low W bits", 2'd0, 2'd0, 2'd0, 2'd1, 64'hFF, 64'd4, 64'hFFF0);
        op_chk("R9 reserved op", 2'd3, 2'd1, 2'd1, 2'd3, 64'hFFFF, 64'd1, 64'h0);
        op_chk("R2 R3 64-bit max amount", 2'd2, 2'd3, 2'd0, 2'd3, 64'h8000_0000_0000_0000, 64'h3F, '1);
        op_chk("R3 mask at 32", 2'd0, 2'd2, 2'd2, 2'd2, 64'h1, 64'd33, 64'h2);
        op_chk("R2 tag from src2", 2'd0, 2'd0, 2'd2, 2'd2, 64'hAB, 64'd12, 64'h000A_B000);

        // Idle cycle with changed inputs: no valid, result held.
        held      = out_data;
        cur_req   = "R10 idle";
        shift_op  = 2'd0;
        src1_data = 64'h1;
        src2_data = 64'd1;
        @(negedge clk);
        #1;
        check("R10 idle valid low", {63'd0, out_valid}, 64'd0);
        check("R10 idle result held", out_data, held);

        // Mixed stream compared against the model on every cycle.
        cur_req = "R1 R4 R5 R6 R7 R8 R9 stream";
        for (int i = 0; i < 3000; i++) begin
            in_valid  = ($urandom_range(0, 3) != 0);
            shift_op  = 2'($urandom_range(0, 3));
            src1_ew   = 2'($urandom_range(0, 3));
            src2_ew   = 2'($urandom_range(0, 3));
            dst_ew    = 2'($urandom_range(0, 3));
            src1_data = {$urandom, $urandom};
            src2_data = {$urandom, $urandom};
            @(negedge clk);
        end
        in_valid = 1'b0;
        @(negedge clk);

        // Reset in mid-stream clears the output stage.
        rst_n = 1'b0;
        @(negedge clk);
        #1;
        check("R11 valid on reset", {63'd0, out_valid}, 64'd0);
        check("R11 data on reset", out_data, 64'd0);

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

endmodule